// File: doc/BRIEF.md
# Dirty Scan-Line Run Coalescer

This block turns per-row dirty information for a framebuffer into a short list of screen update rectangles. On a frame tick it checks the current display mode against the mode it saw last. If the mode is new, it latches that mode and emits one update that covers the whole screen. If the mode is unchanged, it asks the dirty tracker to snapshot and clear the framebuffer's dirty state. It then probes rows 0 through height-1 in order, one probe per cycle.

Each probe gives a byte address and a length. The address is the mode offset plus stride times the row, and the length is one stride. The tracker returns one dirty bit in the same cycle. Adjacent dirty rows are merged into one update record. A record holds a start row, a row count and the full screen width. Records leave through a valid/ready handshake, and the walk pauses while a record is waiting. A busy flag covers the whole run. A tick that arrives while busy is dropped.

Top module: `dirty_run_coalescer`

## Requirements
- R1: After reset the block is idle: busy, record valid, snapshot request and probe are all low.
- R2: A tick with the mode-valid input low does nothing. No snapshot, probe or record follows, and busy stays low.
- R3: A tick with a valid mode that is the first one, or that differs from the latched mode in width, height, stride or offset, latches the mode. It then emits exactly one record with start row 0 and row count equal to the height, and makes no snapshot request and no probe.
- R4: A tick with a valid, unchanged mode raises the snapshot request for exactly one cycle. The request carries base equal to the offset and length equal to stride times height, and it comes in the cycle just before the first probe.
- R5: After a snapshot the block probes rows 0 to height-1 in ascending order. Row r uses address offset + stride*r and length stride. The block makes exactly height probes.
- R6: Each maximal run of contiguous dirty rows produces one record. Its start row is the run's first row and its row count is the run's length. Records come out in ascending row order, and a scan with no dirty rows produces no record.
- R7: A run that is still open after row height-1 is emitted with row count height minus its start row.
- R8: Every record carries the latched width as its column count.
- R9: While a record is valid and not accepted, the record stays valid with unchanged fields and no probe is issued.
- R10: Busy goes high in the cycle after an accepted tick and stays high until the last record is accepted or the scan ends. A tick seen while busy is ignored and does not start another pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Frame tick pulse |
| mode_ok_i | input | 1 | Current mode is valid |
| mode_width_i | input | ROW_W | Mode width in pixels |
| mode_height_i | input | ROW_W | Mode height in rows |
| mode_stride_i | input | STRIDE_W | Bytes per row |
| mode_offset_i | input | ADDR_W | Byte offset of the visible area |
| snap_o | output | 1 | Snapshot-and-clear request |
| snap_base_o | output | ADDR_W | Snapshot region base |
| snap_len_o | output | ADDR_W | Snapshot region length |
| probe_o | output | 1 | Row dirty probe valid |
| probe_addr_o | output | ADDR_W | Probed row byte address |
| probe_len_o | output | STRIDE_W | Probed row byte length |
| probe_dirty_i | input | 1 | Dirty answer for the current probe |
| upd_valid_o | output | 1 | Update record valid |
| upd_ready_i | input | 1 | Update record accepted |
| upd_row_o | output | ROW_W | First row of the update |
| upd_rows_o | output | ROW_W | Number of rows in the update |
| upd_cols_o | output | ROW_W | Update width (full screen) |
| busy_o | output | 1 | Pass in progress |

## Verification
The bench goes after the edges of runs. A design that forgot the final flush would drop a run touching the last row. A design that emitted the wrong length on a clean row would report runs one row too long or too short. Patterns with only the first row dirty, only the last row dirty, every row dirty, none dirty and alternating rows pin these down, and random patterns with random back-pressure check that a stalled record holds steady and that no row is skipped or probed twice. Changing one mode field at a time proves the full-screen path is taken without a snapshot. A tick during a scan or with no valid mode proves that no extra pass starts.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FULL,
    ST_SNAP,
    ST_SCAN,
    ST_EMIT
  } dcl_state_e;
endpackage

// File: rtl/dcl_mode_latch.sv
module dcl_mode_latch #(
  parameter int ROW_W    = 12,
  parameter int STRIDE_W = 16,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ROW_W-1:0]    width_i,
  input  logic [ROW_W-1:0]    height_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [ADDR_W-1:0]   offset_i,
  output logic                differ,
  output logic [ROW_W-1:0]    width_q,
  output logic [ROW_W-1:0]    height_q,
  output logic [STRIDE_W-1:0] stride_q,
  output logic [ADDR_W-1:0]   offset_q
);
  logic have_q;

  always_comb begin
    differ = !have_q || (width_i != width_q) || (height_i != height_q) ||
             (stride_i != stride_q) || (offset_i != offset_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      stride_q <= '0;
      offset_q <= '0;
    end else if (load) begin
      have_q   <= 1'b1;
      width_q  <= width_i;
      height_q <= height_i;
      stride_q <= stride_i;
      offset_q <= offset_i;
    end
  end
endmodule

// File: rtl/dcl_row_walker.sv
module dcl_row_walker #(
  parameter int ROW_W    = 12,
  parameter int STRIDE_W = 16,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                step,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [ROW_W-1:0]    row_q,
  output logic [ADDR_W-1:0]   addr_q
);
  logic [ROW_W-1:0]  row_d;
  logic [ADDR_W-1:0] addr_d;
  logic              en;

  always_comb begin
    en     = clr || step;
    row_d  = clr ? '0 : row_q + 1'b1;
    addr_d = clr ? base_i : addr_q + ADDR_W'(stride_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      addr_q <= '0;
    end else if (en) begin
      row_q  <= row_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dcl_run_tracker.sv
module dcl_run_tracker #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_q,
  output logic [ROW_W-1:0] start_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (open_set || open_clr) begin
      open_q <= open_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (open_set) begin
      start_q <= row_i;
    end
  end

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_set && open_clr)); // R6
endmodule

// File: rtl/dirty_run_coalescer.sv
module dirty_run_coalescer
  import dcl_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int STRIDE_W = 16,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                mode_ok_i,
  input  logic [ROW_W-1:0]    mode_width_i,
  input  logic [ROW_W-1:0]    mode_height_i,
  input  logic [STRIDE_W-1:0] mode_stride_i,
  input  logic [ADDR_W-1:0]   mode_offset_i,
  output logic                snap_o,
  output logic [ADDR_W-1:0]   snap_base_o,
  output logic [ADDR_W-1:0]   snap_len_o,
  output logic                probe_o,
  output logic [ADDR_W-1:0]   probe_addr_o,
  output logic [STRIDE_W-1:0] probe_len_o,
  input  logic                probe_dirty_i,
  output logic                upd_valid_o,
  input  logic                upd_ready_i,
  output logic [ROW_W-1:0]    upd_row_o,
  output logic [ROW_W-1:0]    upd_rows_o,
  output logic [ROW_W-1:0]    upd_cols_o,
  output logic                busy_o
);
  dcl_state_e st_q, st_d;

  logic                mode_new, mode_load;
  logic [ROW_W-1:0]    wid_q, hgt_q;
  logic [STRIDE_W-1:0] str_q;
  logic [ADDR_W-1:0]   off_q;

  logic                walk_clr, walk_step;
  logic [ROW_W-1:0]    row_q;
  logic [ADDR_W-1:0]   addr_q;

  logic                run_set, run_clr, run_open;
  logic [ROW_W-1:0]    run_start;

  logic                pend_ld, pend_last_d, pend_last_q;
  logic [ROW_W-1:0]    pend_rows_d, pend_rows_q;
  logic                at_end;

  dcl_mode_latch #(.ROW_W(ROW_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load),
    .width_i(mode_width_i), .height_i(mode_height_i),
    .stride_i(mode_stride_i), .offset_i(mode_offset_i),
    .differ(mode_new), .width_q(wid_q), .height_q(hgt_q),
    .stride_q(str_q), .offset_q(off_q)
  );

  dcl_row_walker #(.ROW_W(ROW_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(walk_clr), .step(walk_step),
    .base_i(off_q), .stride_i(str_q), .row_q(row_q), .addr_q(addr_q)
  );

  dcl_run_tracker #(.ROW_W(ROW_W)) u_run (
    .clk(clk), .rst_n(rst_n), .open_set(run_set), .open_clr(run_clr),
    .row_i(row_q), .open_q(run_open), .start_q(run_start)
  );

  assign at_end = (row_q == hgt_q);

  always_comb begin
    st_d        = st_q;
    mode_load   = 1'b0;
    walk_clr    = 1'b0;
    walk_step   = 1'b0;
    run_set     = 1'b0;
    run_clr     = 1'b0;
    pend_ld     = 1'b0;
    pend_rows_d = pend_rows_q;
    pend_last_d = pend_last_q;
    case (st_q)
      ST_IDLE: begin
        if (tick_i && mode_ok_i) begin
          if (mode_new) begin
            mode_load = 1'b1;
            st_d      = ST_FULL;
          end else begin
            st_d = ST_SNAP;
          end
        end
      end
      ST_FULL: begin
        if (upd_ready_i) st_d = ST_IDLE;
      end
      ST_SNAP: begin
        walk_clr = 1'b1;
        run_clr  = 1'b1;
        st_d     = ST_SCAN;
      end
      ST_SCAN: begin
        if (at_end) begin
          if (run_open) begin
            pend_ld     = 1'b1;
            pend_rows_d = hgt_q - run_start;
            pend_last_d = 1'b1;
            st_d        = ST_EMIT;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          walk_step = 1'b1;
          if (probe_dirty_i && !run_open) begin
            run_set = 1'b1;
          end else if (!probe_dirty_i && run_open) begin
            pend_ld     = 1'b1;
            pend_rows_d = row_q - run_start;
            pend_last_d = 1'b0;
            st_d        = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (upd_ready_i) begin
          run_clr = 1'b1;
          st_d    = pend_last_q ? ST_IDLE : ST_SCAN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rows_q <= '0;
      pend_last_q <= 1'b0;
    end else if (pend_ld) begin
      pend_rows_q <= pend_rows_d;
      pend_last_q <= pend_last_d;
    end
  end

  always_comb begin
    busy_o       = (st_q != ST_IDLE);
    snap_o       = (st_q == ST_SNAP);
    snap_base_o  = off_q;
    snap_len_o   = ADDR_W'(str_q) * ADDR_W'(hgt_q);
    probe_o      = (st_q == ST_SCAN) && !at_end;
    probe_addr_o = addr_q;
    probe_len_o  = str_q;
    upd_valid_o  = (st_q == ST_FULL) || (st_q == ST_EMIT);
    upd_row_o    = (st_q == ST_FULL) ? '0 : run_start;
    upd_rows_o   = (st_q == ST_FULL) ? hgt_q : pend_rows_q;
    upd_cols_o   = wid_q;
  end

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_o && !upd_ready_i) |=>
      (upd_valid_o && $stable(upd_row_o) && $stable(upd_rows_o))); // R9
  AST_STALL_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_o |-> !probe_o); // R9
  AST_REC_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_o |-> ((upd_rows_o != '0) &&
      (({1'b0, upd_row_o} + {1'b0, upd_rows_o}) <= {1'b0, hgt_q}))); // R6
  AST_SNAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o |=> (!snap_o && busy_o)); // R4
  AST_PROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    probe_o |-> busy_o); // R10
endmodule

// File: tb/dirty_run_coalescer_test.sv
module dirty_run_coalescer_test;
  localparam int ROW_W    = 12;
  localparam int STRIDE_W = 16;
  localparam int ADDR_W   = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n, tick, mode_ok, ready, dirty;
  logic [ROW_W-1:0]    m_w, m_h;
  logic [STRIDE_W-1:0] m_s;
  logic [ADDR_W-1:0]   m_o;
  logic                snap, probe, uvalid, busy;
  logic [ADDR_W-1:0]   snap_base, snap_len, paddr;
  logic [STRIDE_W-1:0] plen;
  logic [ROW_W-1:0]    urow, urows, ucols;

  dirty_run_coalescer #(.ROW_W(ROW_W), .STRIDE_W(STRIDE_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_ok_i(mode_ok),
    .mode_width_i(m_w), .mode_height_i(m_h), .mode_stride_i(m_s), .mode_offset_i(m_o),
    .snap_o(snap), .snap_base_o(snap_base), .snap_len_o(snap_len),
    .probe_o(probe), .probe_addr_o(paddr), .probe_len_o(plen), .probe_dirty_i(dirty),
    .upd_valid_o(uvalid), .upd_ready_i(ready), .upd_row_o(urow), .upd_rows_o(urows),
    .upd_cols_o(ucols), .busy_o(busy)
  );

  int checks = 0, errors = 0;
  bit live[64];
  bit snapb[64];
  int rec_row[64], rec_cnt[64], rec_n;
  int exp_row[64], exp_cnt[64], exp_n;
  int snaps, probe_next;
  bit snap_prev, hold_pend, stall_en;
  int hold_row, hold_cnt;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always_comb begin
    longint idx;
    idx = (m_s != 0) ? (longint'(paddr) - longint'(m_o)) / longint'(m_s) : 0;
    dirty = (probe && idx >= 0 && idx < 64) ? snapb[idx] : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(uvalid && urow == hold_row && urows == hold_cnt, "R9 stalled record held",
            urow, hold_row);
        hold_pend = 0;
      end
      if (snap) begin
        snaps++;
        chk(snap_base == m_o, "R4 snapshot base", snap_base, m_o);
        chk(snap_len == m_s * m_h, "R4 snapshot length", snap_len, m_s * m_h);
        for (int i = 0; i < 64; i++) begin
          snapb[i] = live[i];
          live[i]  = 0;
        end
        probe_next = 0;
      end
      if (probe) begin
        if (probe_next == 0) chk(snap_prev, "R4 snapshot before first probe", 0, 1);
        chk(paddr == m_o + m_s * probe_next, "R5 probe address", paddr, m_o + m_s * probe_next);
        chk(plen == m_s, "R5 probe length", plen, m_s);
        chk(probe_next < m_h, "R5 probe row in range", probe_next, m_h);
        chk(!uvalid, "R9 no probe while record pending", uvalid, 0);
        probe_next++;
      end
      if (uvalid && ready) begin
        chk(ucols == m_w, "R8 record width", ucols, m_w);
        if (rec_n < 64) begin
          rec_row[rec_n] = urow;
          rec_cnt[rec_n] = urows;
        end
        rec_n++;
      end
      if (uvalid && !ready) begin
        hold_pend = 1;
        hold_row  = urow;
        hold_cnt  = urows;
      end
      snap_prev = snap;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  function automatic void build_exp(bit [63:0] p, int h);
    int s;
    s = -1;
    exp_n = 0;
    for (int r = 0; r < h; r++) begin
      if (p[r] && s < 0) s = r;
      else if (!p[r] && s >= 0) begin
        exp_row[exp_n] = s;
        exp_cnt[exp_n] = r - s;
        exp_n++;
        s = -1;
      end
    end
    if (s >= 0) begin
      exp_row[exp_n] = s;
      exp_cnt[exp_n] = h - s;
      exp_n++;
    end
  endfunction

  task automatic pulse_tick();
    @(posedge clk);
    #1 tick = 1;
    @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic trial_full(int h);
    int s0;
    s0 = snaps;
    rec_n = 0;
    pulse_tick();
    chk(busy, "R10 busy after tick", busy, 1);
    wait_idle();
    chk(rec_n == 1, "R3 one full record", rec_n, 1);
    chk(rec_row[0] == 0, "R3 full record start", rec_row[0], 0);
    chk(rec_cnt[0] == h, "R3 full record rows", rec_cnt[0], h);
    chk(snaps == s0, "R3 no snapshot on mode change", snaps - s0, 0);
  endtask

  task automatic trial_scan(bit [63:0] p, bit extra_tick);
    int s0;
    int h;
    h = int'(m_h);
    s0 = snaps;
    rec_n = 0;
    for (int i = 0; i < 64; i++) live[i] = p[i];
    build_exp(p, h);
    pulse_tick();
    chk(busy, "R10 busy after tick", busy, 1);
    if (extra_tick) begin
      repeat (2) @(posedge clk);
      #1 tick = 1;
      chk(busy, "R10 busy during second tick", busy, 1);
      @(posedge clk);
      #1 tick = 0;
    end
    wait_idle();
    repeat (3) @(negedge clk);
    chk(!busy, "R10 tick while busy ignored", busy, 0);
    chk(snaps == s0 + 1, "R10 one pass per tick", snaps - s0, 1);
    chk(probe_next == h, "R5 probe count", probe_next, h);
    chk(rec_n == exp_n, "R6 record count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      chk(rec_row[i] == exp_row[i], "R6 record start row", rec_row[i], exp_row[i]);
      chk(rec_cnt[i] == exp_cnt[i], "R7 record row count", rec_cnt[i], exp_cnt[i]);
    end
  endtask

  task automatic set_mode(int w, int h, int s, int o);
    m_w = ROW_W'(w);
    m_h = ROW_W'(h);
    m_s = STRIDE_W'(s);
    m_o = ADDR_W'(o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [63:0] pat;
    int h;
    void'($urandom(32'd20240611));
    rst_n = 0; tick = 0; mode_ok = 0; ready = 1; stall_en = 0;
    rec_n = 0; snaps = 0; probe_next = 0; snap_prev = 0; hold_pend = 0;
    for (int i = 0; i < 64; i++) begin live[i] = 0; snapb[i] = 0; end
    set_mode(640, 20, 1280, 4096);
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !uvalid && !snap && !probe, "R1 idle after reset",
        {busy, uvalid, snap, probe}, 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !uvalid, "R1 idle after release", {busy, uvalid}, 0);

    pulse_tick();
    repeat (5) @(negedge clk);
    chk(!busy && rec_n == 0 && snaps == 0, "R2 tick without valid mode", rec_n + snaps, 0);

    mode_ok = 1;
    trial_full(20);
    trial_scan(64'hFFFFF, 0);
    trial_scan(64'h0, 0);
    trial_scan(64'h80000, 0);
    trial_scan(64'h1, 0);
    trial_scan(64'h55555, 0);
    trial_scan(64'hC0F0E, 1);

    set_mode(640, 20, 1344, 4096);
    trial_full(20);
    set_mode(640, 21, 1344, 4096);
    trial_full(21);
    set_mode(800, 21, 1344, 4096);
    trial_full(21);
    set_mode(800, 21, 1344, 8192);
    trial_full(21);

    stall_en = 1;
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 4 == 0) begin
        h = 8 + int'($urandom % 33);
        set_mode(1 + int'($urandom % 4000), h, 1 + int'($urandom % 3000),
                 int'($urandom % 65536));
        trial_full(h);
      end
      pat = {$urandom, $urandom};
      if ($urandom % 5 == 0) pat = pat & {$urandom, $urandom};
      trial_scan(pat & ((64'd1 << m_h) - 1), ($urandom % 6 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule